// File: doc/BRIEF.md
# Sub-Sampling Readout Sequencer

The block drives the row and column-converter timing for a 144-row by 176-column monochrome pixel array that can be read at seven resolutions. A frame-start strobe latches a 3-bit resolution code. The block then walks the array from top to bottom, selecting one row at a time. It stays on each row until the column converters report completion, and then jumps straight to the next row that the chosen resolution keeps. Rows that are left out cost no clock cycles.

Decimation repeats on an 8x8 pixel tile. Each column converter serves four adjacent columns: the first two columns of a group of four go to that group's odd-bank converter, and the last two go to its even-bank converter. For each frame the block drives an enable per converter in both banks, and a power-down flag per row driver, so that idle rows and whole converter banks can be switched off at lower resolutions. A one-cycle done pulse closes each frame.

Top module: `subsamp_readout_seq`

## Requirements
- R1: After reset, and whenever no frame is running, `rowSel`, `rowValid`, `frameDone`, `oddColEn` and `evenColEn` are all zero and every bit of `rowDrvOff` is one. `adcDone` has no effect while idle.
- R2: The resolution code selects the rows read, where row r counts from 0 at the top. Code 0 (full) reads every row. Code 1 (1/2) reads rows with r mod 4 below 2. Code 2 (1/4) reads even rows. Codes 3 (1/8) and 4 (1/16) read rows with r mod 4 = 0. Codes 5 (1/32) and 6 (1/64) read rows with r mod 8 = 0. Code 7 behaves as full.
- R3: While a frame runs, `rowSel` is one-hot, with bit r selecting row r. `rowValid` is high for exactly the first cycle of each selected row. Row 0 is selected, with `rowValid`, in the cycle after `frameStart` is sampled.
- R4: Rows are read in ascending order. A row stays selected until `adcDone` is sampled high. In the next cycle the next row kept by R2 is selected, and skipped rows take zero cycles.
- R5: Odd-bank converter g serves columns 4g and 4g+1, and even-bank converter g serves columns 4g+2 and 4g+3. During a frame, even-bank converters are all enabled for codes 0 to 3 and 7, and all disabled for codes 4 to 6. Odd-bank converters are all enabled, except under code 6, where only those with even g are enabled.
- R6: During a frame, `rowDrvOff[r]` is high exactly when row r is not read under the latched code.
- R7: When `adcDone` is sampled on the last kept row, the next cycle has `frameDone` high for one cycle and `rowSel` all zero.
- R8: The resolution code is sampled only when a frame starts. Changes on `modeCode` and further `frameStart` pulses during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Starts a frame when idle |
| modeCode | input | 3 | Resolution code, latched at frame start |
| adcDone | input | 1 | Converters finished the current row |
| rowSel | output | 144 | One-hot row select |
| rowValid | output | 1 | First cycle of a newly selected row |
| oddColEn | output | 44 | Odd-bank converter enables |
| evenColEn | output | 44 | Even-bank converter enables |
| rowDrvOff | output | 144 | Row-driver power-down flags |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that `adcDone` acts as a single-cycle acknowledgement for the row currently selected, and that reset is held low for at least one clock edge before any strobe arrives. The bench pulses `adcDone` for exactly one cycle per row. It holds each row for zero to several cycles first, so that back-to-back stepping and waiting both occur. It raises `frameStart` only for a single cycle, either while idle or in the deliberate mid-frame test.

// File: rtl/subsamp_pkg.sv
package subsamp_pkg;

  typedef enum logic [2:0] {
    MODE_FULL     = 3'd0,
    MODE_HALF     = 3'd1,
    MODE_QUARTER  = 3'd2,
    MODE_EIGHTH   = 3'd3,
    MODE_SIXTEEN  = 3'd4,
    MODE_THIRTY2  = 3'd5,
    MODE_SIXTY4   = 3'd6,
    MODE_ALTFULL  = 3'd7
  } resMode_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } seqCtrl_t;

  // Whether a row whose index mod 8 is rowLow is read in mode m
  function automatic logic rowKept(input logic [2:0] rowLow, input resMode_e m);
    case (m)
      MODE_HALF:                  return !rowLow[1];
      MODE_QUARTER:               return !rowLow[0];
      MODE_EIGHTH, MODE_SIXTEEN:  return rowLow[1:0] == 2'd0;
      MODE_THIRTY2, MODE_SIXTY4:  return rowLow == 3'd0;
      default:                    return 1'b1;
    endcase
  endfunction

  // Distance from a kept row to the next kept row
  function automatic logic [3:0] rowStep(input logic [2:0] rowLow, input resMode_e m);
    case (m)
      MODE_HALF:                  return rowLow[0] ? 4'd3 : 4'd1;
      MODE_QUARTER:               return 4'd2;
      MODE_EIGHTH, MODE_SIXTEEN:  return 4'd4;
      MODE_THIRTY2, MODE_SIXTY4:  return 4'd8;
      default:                    return 4'd1;
    endcase
  endfunction

  // log2 of the kept-column stride
  function automatic logic [1:0] colShiftOf(input resMode_e m);
    case (m)
      MODE_QUARTER, MODE_EIGHTH:  return 2'd1;
      MODE_SIXTEEN, MODE_THIRTY2: return 2'd2;
      MODE_SIXTY4:                return 2'd3;
      default:                    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/subsamp_ctrl.sv
module subsamp_ctrl
  import subsamp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStart,
  input  logic     adcDone,
  input  logic     lastRow,
  output logic     busy,
  output seqCtrl_t ctrl,
  output logic     rowValid,
  output logic     frameDone
);

  typedef enum logic {ST_IDLE, ST_SCAN} seqState_e;
  seqState_e state;

  assign busy = (state == ST_SCAN);

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && frameStart;
    ctrl.step   = busy && adcDone && !lastRow;
    ctrl.finish = busy && adcDone && lastRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rowValid  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      if (ctrl.load)        state <= ST_SCAN;
      else if (ctrl.finish) state <= ST_IDLE;
      rowValid  <= ctrl.load | ctrl.step;
      frameDone <= ctrl.finish;
    end
  end

  // R7: done is a single-cycle pulse and the scan has stopped
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !busy);
  // R3: a new-row strobe only appears during a scan
  p_valid_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    rowValid |-> busy);
  // R8: without an acknowledgement, a running scan neither restarts nor moves
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !adcDone |=> busy && !rowValid);

endmodule

// File: rtl/subsamp_path.sv
module subsamp_path
  import subsamp_pkg::*;
#(
  parameter int NUM_ROWS = 144,
  parameter int NUM_COLS = 176
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCtrl_t              ctrl,
  input  logic                  busy,
  input  logic [2:0]            modeCode,
  output logic                  lastRow,
  output logic [NUM_ROWS-1:0]   rowSel,
  output logic [NUM_COLS/4-1:0] oddColEn,
  output logic [NUM_COLS/4-1:0] evenColEn,
  output logic [NUM_ROWS-1:0]   rowDrvOff
);

  localparam int ROW_W   = $clog2(NUM_ROWS);
  localparam int NUM_GRP = NUM_COLS / 4;
  localparam logic [ROW_W:0] ROW_LIMIT = (ROW_W+1)'(NUM_ROWS);

  resMode_e         modeReg;
  logic [ROW_W-1:0] rowIdx;
  logic [ROW_W:0]   nextRow;
  logic [3:0]       stepVal;
  logic [1:0]       colShift;

  always_comb begin
    stepVal  = rowStep(rowIdx[2:0], modeReg);
    nextRow  = {1'b0, rowIdx} + {{(ROW_W-3){1'b0}}, stepVal};
    lastRow  = (nextRow >= ROW_LIMIT);
    colShift = colShiftOf(modeReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_FULL;
      rowIdx  <= '0;
    end else if (ctrl.load) begin
      modeReg <= resMode_e'(modeCode);
      rowIdx  <= '0;
    end else if (ctrl.step) begin
      rowIdx  <= nextRow[ROW_W-1:0];
    end else if (ctrl.finish) begin
      rowIdx  <= '0;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam logic [2:0] LOW = 3'(r % 8);
    assign rowSel[r]    = busy && (rowIdx == ROW_W'(r));
    assign rowDrvOff[r] = !busy || !rowKept(LOW, modeReg);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam bit EVEN_GRP = (g % 2) == 0;
    assign oddColEn[g]  = busy && ((colShift != 2'd3) || EVEN_GRP);
    assign evenColEn[g] = busy && (colShift <= 2'd1);
  end

  // R3: exactly one row selected during a scan
  p_row_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $onehot(rowSel));
  // R6: the selected row's driver is never flagged off
  p_sel_driver_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rowSel & rowDrvOff) == '0);
  // R4: every step moves strictly downward through the array
  p_row_ascend_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> rowIdx > $past(rowIdx));
  // R8: the latched code does not change during a scan
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modeReg));
  // R5: low modes leave the even bank dark
  p_even_bank_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_SIXTEEN || modeReg == MODE_THIRTY2 || modeReg == MODE_SIXTY4)
      |-> evenColEn == '0);

endmodule

// File: rtl/subsamp_readout_seq.sv
module subsamp_readout_seq
  import subsamp_pkg::*;
#(
  parameter int NUM_ROWS = 144,
  parameter int NUM_COLS = 176
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameStart,
  input  logic [2:0]            modeCode,
  input  logic                  adcDone,
  output logic [NUM_ROWS-1:0]   rowSel,
  output logic                  rowValid,
  output logic [NUM_COLS/4-1:0] oddColEn,
  output logic [NUM_COLS/4-1:0] evenColEn,
  output logic [NUM_ROWS-1:0]   rowDrvOff,
  output logic                  frameDone
);

  seqCtrl_t ctrl;
  logic     busy;
  logic     lastRow;

  subsamp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .adcDone    (adcDone),
    .lastRow    (lastRow),
    .busy       (busy),
    .ctrl       (ctrl),
    .rowValid   (rowValid),
    .frameDone  (frameDone)
  );

  subsamp_path #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .busy      (busy),
    .modeCode  (modeCode),
    .lastRow   (lastRow),
    .rowSel    (rowSel),
    .oddColEn  (oddColEn),
    .evenColEn (evenColEn),
    .rowDrvOff (rowDrvOff)
  );

endmodule

// File: tb/tb_subsamp_readout_seq.sv
module tb_subsamp_readout_seq;

  localparam int ROWS = 144;
  localparam int GRPS = 44;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameStart = 1'b0;
  logic [2:0]      modeCode = 3'd0;
  logic            adcDone = 1'b0;
  logic [ROWS-1:0] rowSel;
  logic            rowValid;
  logic [GRPS-1:0] oddColEn;
  logic [GRPS-1:0] evenColEn;
  logic [ROWS-1:0] rowDrvOff;
  logic            frameDone;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  subsamp_readout_seq dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .modeCode(modeCode),
    .adcDone(adcDone), .rowSel(rowSel), .rowValid(rowValid),
    .oddColEn(oddColEn), .evenColEn(evenColEn), .rowDrvOff(rowDrvOff),
    .frameDone(frameDone)
  );

  // {mode code, rows read, odd converters on, even converters on, hold cycles}
  localparam int VEC[8][5] = '{
    '{0, 144, 44, 44, 0},
    '{1,  72, 44, 44, 1},
    '{2,  72, 44, 44, 2},
    '{3,  36, 44, 44, 0},
    '{4,  36, 44,  0, 3},
    '{5,  18, 44,  0, 1},
    '{6,  18, 22,  0, 2},
    '{7, 144, 44, 44, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // Row set per mode, taken from R2
  function automatic bit keepRow(input int mode, input int r);
    case (mode)
      1:       return (r % 4) < 2;
      2:       return (r % 2) == 0;
      3, 4:    return (r % 4) == 0;
      5, 6:    return (r % 8) == 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int selIdx();
    int idx = -1;
    for (int i = 0; i < ROWS; i++) if (rowSel[i]) idx = i;
    return idx;
  endfunction

  function automatic int nextKept(input int mode, input int r);
    int n = r + 1;
    while (n < ROWS && !keepRow(mode, n)) n++;
    return n;
  endfunction

  task automatic checkFrameVectors(input int mode);
    logic [ROWS-1:0] expOff;
    logic [GRPS-1:0] expOdd;
    logic [GRPS-1:0] expEven;
    for (int r = 0; r < ROWS; r++) expOff[r] = !keepRow(mode, r);
    for (int g = 0; g < GRPS; g++) begin
      expOdd[g]  = (mode == 6) ? ((g % 2) == 0) : 1'b1;
      expEven[g] = !(mode >= 4 && mode <= 6);
    end
    chk(rowDrvOff == expOff, "R6 row driver flags", $countones(rowDrvOff), $countones(expOff));
    chk(oddColEn == expOdd, "R5 odd bank enables", $countones(oddColEn), $countones(expOdd));
    chk(evenColEn == expEven, "R5 even bank enables", $countones(evenColEn), $countones(expEven));
  endtask

  task automatic runFrame(input int mode, input int hold, output int rowsSeen,
                          output int oddOn, output int evenOn);
    int  expRow = 0;
    bit  done = 0;
    rowsSeen = 0;
    @(negedge clk); frameStart = 1'b1; modeCode = 3'(mode);
    @(negedge clk); frameStart = 1'b0;
    oddOn  = $countones(oddColEn);
    evenOn = $countones(evenColEn);
    checkFrameVectors(mode);
    while (!done) begin
      chk(rowValid == 1'b1, "R3 row valid on new row", rowValid, 1);
      chk($countones(rowSel) == 1, "R3 row select one-hot", $countones(rowSel), 1);
      chk(selIdx() == expRow, "R2 R4 selected row", selIdx(), expRow);
      rowsSeen++;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(rowValid == 1'b0, "R3 row valid single cycle", rowValid, 0);
        chk(selIdx() == expRow, "R4 row held without done", selIdx(), expRow);
      end
      adcDone = 1'b1;
      @(negedge clk); adcDone = 1'b0;
      if (nextKept(mode, expRow) >= ROWS) begin
        chk(frameDone == 1'b1, "R7 frame done after last row", frameDone, 1);
        chk(rowSel == '0, "R7 rows released at end", $countones(rowSel), 0);
        @(negedge clk);
        chk(frameDone == 1'b0, "R7 frame done single cycle", frameDone, 0);
        done = 1;
      end else begin
        expRow = nextKept(mode, expRow);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int rowsSeen, oddOn, evenOn;
    repeat (3) @(negedge clk);
    rowsSeen = 0;
    // R1: reset state
    chk(rowSel == '0, "R1 reset row select", $countones(rowSel), 0);
    chk(rowValid == 1'b0, "R1 reset row valid", rowValid, 0);
    chk(frameDone == 1'b0, "R1 reset frame done", frameDone, 0);
    chk(oddColEn == '0 && evenColEn == '0, "R1 reset converters off",
        $countones(oddColEn) + $countones(evenColEn), 0);
    chk(rowDrvOff == '1, "R1 reset drivers off", $countones(rowDrvOff), ROWS);
    rstN = 1'b1;
    @(negedge clk);
    // R1: acknowledgement while idle does nothing
    adcDone = 1'b1;
    @(negedge clk); adcDone = 1'b0;
    chk(rowValid == 1'b0 && rowSel == '0, "R1 idle ignores done", selIdx(), -1);
    chk(frameDone == 1'b0, "R1 idle no frame done", frameDone, 0);

    for (int v = 0; v < 8; v++) begin
      runFrame(VEC[v][0], VEC[v][4], rowsSeen, oddOn, evenOn);
      chk(rowsSeen == VEC[v][1], "R2 rows per frame", rowsSeen, VEC[v][1]);
      chk(oddOn == VEC[v][2], "R5 odd converters on", oddOn, VEC[v][2]);
      chk(evenOn == VEC[v][3], "R5 even converters on", evenOn, VEC[v][3]);
      chk(rowDrvOff == '1 && oddColEn == '0, "R1 idle after frame",
          $countones(rowDrvOff), ROWS);
    end

    // R8: mode change and restart attempt during a 1/64 frame
    @(negedge clk); frameStart = 1'b1; modeCode = 3'd6;
    @(negedge clk); frameStart = 1'b0;
    chk(selIdx() == 0, "R8 frame began at row 0", selIdx(), 0);
    modeCode = 3'd0; frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    chk(rowValid == 1'b0 && selIdx() == 0, "R8 restart ignored", selIdx(), 0);
    adcDone = 1'b1;
    @(negedge clk); adcDone = 1'b0;
    chk(selIdx() == 8, "R8 latched mode kept", selIdx(), 8);
    chk(evenColEn == '0, "R8 even bank stays off", $countones(evenColEn), 0);
    begin
      int cnt = 2;
      int guard = 0;
      while (guard < 40) begin
        adcDone = 1'b1;
        @(negedge clk); adcDone = 1'b0;
        guard++;
        if (frameDone) break;
        cnt++;
      end
      chk(cnt == 18, "R8 row count of latched mode", cnt, 18);
    end
    @(negedge clk);
    summary();
  end

endmodule